// File: doc/BRIEF.md
# DMA Interrupt and Channel-Enable Register Bank

This block is the software-visible interrupt and enable register bank of a multi-channel DMA engine. Each channel reports five kinds of event as one-cycle pulses: whole transfer finished, block finished, source-side transaction finished, destination-side transaction finished, and error. For every event class the bank keeps a sticky latch per channel (the raw view), a per-channel enable (the mask view), a masked view (status) and a write-only acknowledge register. The masked views are folded into one summary register with one bit per class and into a single interrupt line.

The bank also holds the global engine enable and the per-channel run enables. The mask and channel-enable registers take a write-enable lane in the upper byte of the write data, so software can switch single channels on or off with one write instead of a read-modify-write. Access is through a plain synchronous port: a write lands on the clock edge, and a read returns its data on the cycle after the request.

Address map: `addr[5:3]` selects a group (0 raw, 1 status, 2 mask, 3 acknowledge, 4 miscellaneous) and `addr[2:0]` selects the class inside it (0 transfer, 1 block, 2 source transaction, 3 destination transaction, 4 error). In group 4, index 0 is the summary register, index 1 the global configuration and index 2 the channel-enable register. Bit c of a per-channel register belongs to channel c.

Top module: `dma_irq_regbank`

## Requirements
- R1: An event pulse on channel c of a class sets raw bit c of that class at the next edge; the bit stays set until acknowledged and reads back in group 0.
- R2: Writing the acknowledge register of a class clears each raw bit whose data bit in [7:0] is 1; an event and an acknowledge on the same bit in the same cycle leave the bit set; the acknowledge register reads as 0.
- R3: The status register of a class (group 1) reads as the raw bits ANDed with the mask bits of that class.
- R4: A mask write updates data bit c only when write-enable bit 8+c is 1; other bits keep their value. Mask bits read back in group 2.
- R5: Summary register bit k is the OR of class k's status bits; irqOut is the OR of all five summary bits.
- R6: Global configuration bit 0 drives dmaEnable and reads back in bit 0.
- R7: While the engine is enabled, a channel-enable write updates bit c only when write-enable bit 8+c is 1; the register drives chanEnable and reads back.
- R8: While dmaEnable is 0 the channel-enable bits are 0 and writes to them are ignored; writing 0 to configuration bit 0 clears all channel enables.
- R9: rdData loads on the edge where rdEn is 1 with the register value from before that edge, holds otherwise, and unmapped addresses read 0.
- R10: After reset every register, rdData, irqOut, dmaEnable and chanEnable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request for addr this cycle |
| rdEn | input | 1 | Read request for addr this cycle |
| addr | input | 6 | Register address, group in [5:3], class or index in [2:0] |
| wrData | input | 16 | Write data; [7:0] values, [15:8] write-enable lane where used |
| evXfer | input | NUM_CH | Transfer-finished pulses, one per channel |
| evBlock | input | NUM_CH | Block-finished pulses |
| evSrcTran | input | NUM_CH | Source-transaction-finished pulses |
| evDstTran | input | NUM_CH | Destination-transaction-finished pulses |
| evErr | input | NUM_CH | Error pulses |
| rdData | output | 8 | Registered read data |
| irqOut | output | 1 | Combined interrupt |
| dmaEnable | output | 1 | Global engine enable |
| chanEnable | output | NUM_CH | Per-channel run enables |

## Verification
The assertions assume reset is held low across the first clock edge and that wrEn, rdEn, addr, wrData and the event inputs are settled at each rising edge; they also rely on the port carrying at most one address per cycle, so a configuration write and a channel-enable write never coincide. The bench drives every input on the falling edge from one task, one access per cycle, and keeps the event inputs at zero during reset. Random traffic covers all groups, including unmapped indices and the acknowledge group, with events injected at a low rate so latches both accumulate and get cleared.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_CLASS = 5;
  localparam int ADDR_W    = 6;
  localparam int WR_W      = 16;
  localparam int RD_W      = 8;
  localparam int LANE_LSB  = 8;

  // Group codes carried in addr[5:3]
  localparam logic [2:0] GRP_RAW  = 3'd0;
  localparam logic [2:0] GRP_STAT = 3'd1;
  localparam logic [2:0] GRP_MASK = 3'd2;
  localparam logic [2:0] GRP_ACK  = 3'd3;
  localparam logic [2:0] GRP_MISC = 3'd4;

  // Indices inside the miscellaneous group
  localparam logic [2:0] MISC_SUM  = 3'd0;
  localparam logic [2:0] MISC_CFG  = 3'd1;
  localparam logic [2:0] MISC_CHEN = 3'd2;

  typedef struct packed {
    logic [NUM_CLASS-1:0] wrMask;
    logic [NUM_CLASS-1:0] wrAck;
    logic                 wrCfg;
    logic                 wrChEn;
    logic                 rdLoad;
    logic [2:0]           rdGrp;
    logic [2:0]           rdIdx;
  } strobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  logic [2:0] grp;
  logic [2:0] idx;

  assign grp = addr[5:3];
  assign idx = addr[2:0];

  always_comb begin
    stb = '0;
    stb.rdLoad = rdEn;
    stb.rdGrp  = grp;
    stb.rdIdx  = idx;
    for (int k = 0; k < NUM_CLASS; k++) begin
      stb.wrMask[k] = wrEn && (grp == GRP_MASK) && (idx == 3'(k));
      stb.wrAck[k]  = wrEn && (grp == GRP_ACK)  && (idx == 3'(k));
    end
    stb.wrCfg  = wrEn && (grp == GRP_MISC) && (idx == MISC_CFG);
    stb.wrChEn = wrEn && (grp == GRP_MISC) && (idx == MISC_CHEN);
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             stb,
  input  logic [WR_W-1:0]                     wrData,
  input  logic [NUM_CLASS-1:0][NUM_CH-1:0]    evVec,
  output logic [RD_W-1:0]                     rdData,
  output logic                                irqOut,
  output logic                                dmaEnable,
  output logic [NUM_CH-1:0]                   chanEnable
);
  localparam int LANE_MSB = LANE_LSB + NUM_CH - 1;

  logic [NUM_CLASS-1:0][NUM_CH-1:0] rawQ;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] maskQ;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] statusW;
  logic [NUM_CLASS-1:0]             classHit;
  logic                             enQ;
  logic [NUM_CH-1:0]                chEnQ;
  logic [RD_W-1:0]                  rdQ;
  logic [RD_W-1:0]                  rdNext;
  logic [NUM_CH-1:0]                wrVal;
  logic [NUM_CH-1:0]                weLane;

  assign wrVal  = wrData[NUM_CH-1:0];
  assign weLane = wrData[LANE_MSB:LANE_LSB];

  for (genvar g = 0; g < NUM_CLASS; g++) begin : gClass
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rawQ[g] <= '0;
      end else begin
        rawQ[g] <= (rawQ[g] & ~(stb.wrAck[g] ? wrVal : '0)) | evVec[g];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[g] <= '0;
      end else if (stb.wrMask[g]) begin
        maskQ[g] <= (maskQ[g] & ~weLane) | (wrVal & weLane);
      end
    end

    assign statusW[g]  = rawQ[g] & maskQ[g];
    assign classHit[g] = |statusW[g];

    // R1
    raw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evVec[g] != '0) |=> ((rawQ[g] & $past(evVec[g])) == $past(evVec[g])));
    // R2
    raw_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrAck[g] |=> ((rawQ[g] & $past(wrVal) & ~$past(evVec[g])) == '0));
    // R1
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.wrAck[g] && evVec[g] == '0) |=> $stable(rawQ[g]));
    // R4
    mask_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (((maskQ[g] ^ $past(maskQ[g])) &
                 ~($past(stb.wrMask[g]) ? $past(weLane) : '0)) == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
    end else if (stb.wrCfg) begin
      enQ <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEnQ <= '0;
    end else if (stb.wrCfg && !wrData[0]) begin
      chEnQ <= '0;
    end else if (stb.wrChEn && enQ) begin
      chEnQ <= (chEnQ & ~weLane) | (wrVal & weLane);
    end
  end

  // R8
  chen_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> (chEnQ == '0));
  // R7
  chen_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrChEn && enQ) |=> (((chEnQ ^ $past(chEnQ)) & ~$past(weLane)) == '0));

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < NUM_CLASS; k++) begin
      if (stb.rdIdx == 3'(k)) begin
        if (stb.rdGrp == GRP_RAW)  rdNext[NUM_CH-1:0] = rawQ[k];
        if (stb.rdGrp == GRP_STAT) rdNext[NUM_CH-1:0] = statusW[k];
        if (stb.rdGrp == GRP_MASK) rdNext[NUM_CH-1:0] = maskQ[k];
      end
    end
    if (stb.rdGrp == GRP_MISC) begin
      if (stb.rdIdx == MISC_SUM)  rdNext[NUM_CLASS-1:0] = classHit;
      if (stb.rdIdx == MISC_CFG)  rdNext[0] = enQ;
      if (stb.rdIdx == MISC_CHEN) rdNext[NUM_CH-1:0] = chEnQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (stb.rdLoad) begin
      rdQ <= rdNext;
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(rdData));

  assign rdData     = rdQ;
  assign irqOut     = |classHit;
  assign dmaEnable  = enQ;
  assign chanEnable = chEnQ;
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WR_W-1:0]   wrData,
  input  logic [NUM_CH-1:0] evXfer,
  input  logic [NUM_CH-1:0] evBlock,
  input  logic [NUM_CH-1:0] evSrcTran,
  input  logic [NUM_CH-1:0] evDstTran,
  input  logic [NUM_CH-1:0] evErr,
  output logic [RD_W-1:0]   rdData,
  output logic              irqOut,
  output logic              dmaEnable,
  output logic [NUM_CH-1:0] chanEnable
);
  strobe_t                          stb;
  logic [NUM_CLASS-1:0][NUM_CH-1:0] evVec;

  assign evVec = {evErr, evDstTran, evSrcTran, evBlock, evXfer};

  dma_irq_ctrl uCtrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .evVec      (evVec),
    .rdData     (rdData),
    .irqOut     (irqOut),
    .dmaEnable  (dmaEnable),
    .chanEnable (chanEnable)
  );
endmodule

// File: tb/tb_dma_irq_regbank.sv
module tb_dma_irq_regbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [4:0][7:0] evB = '0;
  logic [7:0]  rdData;
  logic        irqOut;
  logic        dmaEnable;
  logic [7:0]  chanEnable;

  always #4 clk = ~clk;

  dma_irq_regbank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .evXfer(evB[0]), .evBlock(evB[1]), .evSrcTran(evB[2]),
    .evDstTran(evB[3]), .evErr(evB[4]), .rdData(rdData), .irqOut(irqOut),
    .dmaEnable(dmaEnable), .chanEnable(chanEnable)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural model state
  bit [7:0] mRaw [5];
  bit [7:0] mMask [5];
  bit       mEn = 0;
  bit [7:0] mChEn = 0;
  bit [7:0] mRd = 0;
  string    mRdTag = "R10";

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] modelRead(bit [5:0] a, output string tag);
    bit [7:0] v = 0;
    int grp = a[5:3];
    int idx = a[2:0];
    tag = "R9";
    if (grp <= 2 && idx < 5) begin
      if (grp == 0) begin v = mRaw[idx]; tag = "R1"; end
      if (grp == 1) begin v = mRaw[idx] & mMask[idx]; tag = "R3"; end
      if (grp == 2) begin v = mMask[idx]; tag = "R4"; end
    end else if (grp == 3) begin
      tag = "R2";
    end else if (grp == 4 && idx == 0) begin
      for (int k = 0; k < 5; k++) v[k] = |(mRaw[k] & mMask[k]);
      tag = "R5";
    end else if (grp == 4 && idx == 1) begin
      v[0] = mEn; tag = "R6";
    end else if (grp == 4 && idx == 2) begin
      v = mChEn; tag = "R7";
    end
    return v;
  endfunction

  function automatic bit modelIrq();
    bit r = 0;
    for (int k = 0; k < 5; k++) r |= |(mRaw[k] & mMask[k]);
    return r;
  endfunction

  task automatic compareAll();
    check("R5 irqOut", irqOut, modelIrq());
    check("R6 dmaEnable", dmaEnable, mEn);
    check(mEn ? "R7 chanEnable" : "R8 chanEnable", chanEnable, mChEn);
    check({mRdTag, " rdData"}, rdData, mRd);
  endtask

  // one clock: drive at falling edge, update model, compare at next falling edge
  task automatic step(bit w, bit r, bit [5:0] a, bit [15:0] d, bit [4:0][7:0] e);
    int grp = a[5:3];
    int idx = a[2:0];
    bit oldEn = mEn;
    string t;
    wrEn = w; rdEn = r; addr = a; wrData = d; evB = e;
    if (r) begin
      mRd = modelRead(a, t);
      mRdTag = t;
    end
    for (int k = 0; k < 5; k++) begin
      bit [7:0] ack = (w && grp == 3 && idx == k) ? d[7:0] : 8'h00;
      mRaw[k] = (mRaw[k] & ~ack) | e[k];
      if (w && grp == 2 && idx == k)
        mMask[k] = (mMask[k] & ~d[15:8]) | (d[7:0] & d[15:8]);
    end
    if (w && grp == 4 && idx == 1) begin
      mEn = d[0];
      if (!d[0]) mChEn = 0;
    end
    if (w && grp == 4 && idx == 2 && oldEn)
      mChEn = (mChEn & ~d[15:8]) | (d[7:0] & d[15:8]);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(bit [5:0] a, bit [15:0] d);
    step(1, 0, a, d, '0);
  endtask

  task automatic rd(bit [5:0] a);
    step(0, 1, a, 16'h0, '0);
    step(0, 0, 6'h0, 16'h0, '0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    bit [4:0][7:0] e;
    for (int k = 0; k < 5; k++) begin mRaw[k] = 0; mMask[k] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rdData", rdData, 0);
    check("R10 irqOut", irqOut, 0);
    check("R10 dmaEnable", dmaEnable, 0);
    check("R10 chanEnable", chanEnable, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: channel enable ignored while engine disabled
    wr(6'h22, 16'hFFFF);
    rd(6'h22);
    // R6 / R7: enable engine then use lanes
    wr(6'h21, 16'h0001);
    rd(6'h21);
    wr(6'h22, 16'h0505);
    rd(6'h22);
    wr(6'h22, 16'h0104);     // clears ch0 only, ch2 untouched
    rd(6'h22);
    // R1 / R3: event on transfer class channel 3, masked off
    e = '0; e[0] = 8'h08;
    step(0, 0, 6'h0, 16'h0, e);
    rd(6'h00);
    rd(6'h08);
    // R4 / R5: unmask ch3 of transfer class
    wr(6'h10, 16'h0808);
    rd(6'h20);
    rd(6'h10);
    // R2: acknowledge, read of acknowledge reg is zero
    wr(6'h18, 16'h0008);
    rd(6'h18);
    // R2: event and acknowledge in the same cycle, set wins
    e = '0; e[0] = 8'h08;
    step(1, 0, 6'h18, 16'h00FF, e);
    rd(6'h00);
    // R9: unmapped address and read of data before same-cycle event
    rd(6'h3F);
    e = '0; e[4] = 8'h81;
    step(0, 1, 6'h04, 16'h0, e);
    rd(6'h04);
    // R8: disabling clears channel enables
    wr(6'h21, 16'h0000);
    rd(6'h22);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit [5:0] a;
      bit [15:0] d = 16'($urandom);
      bit w = ($urandom_range(0, 2) == 0);
      bit r = ($urandom_range(0, 1) == 0);
      a = {3'($urandom_range(0, 5)), 3'($urandom_range(0, 7))};
      if ($urandom_range(0, 9) == 0) a = 6'h21;
      for (int k = 0; k < 5; k++)
        e[k] = ($urandom_range(0, 7) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      step(w, r, a, d, e);
    end
    report();
  end
endmodule